// File: doc/BRIEF.md
# Descriptor-Driven Configuration Copy Engine

This block moves bytes out of a firmware-configuration item into system memory, under the control of a small descriptor that software places in RAM. Software writes the descriptor's physical address into a 64-bit pointer register. The register is written as two 32-bit halves, and writing the low half starts the engine. The engine reads the four descriptor words and checks the request. It then either copies bytes of the currently selected item to the target address, or discards them when the target address is zero. Last, it writes the updated target address, remaining length and a status word back into the descriptor.

The block has three interfaces. The register write port carries the pointer halves. A simple memory master port performs word reads, word writes and single-byte writes, with a request/acknowledge handshake. A byte source presents the byte at the current item offset, reports the item size and offset, and advances the offset by one for each pulse of the advance output. The engine also drives a constant interface revision of 2, which identifies the device as one that supports this copy mode.

The controller has twelve named states. ST_IDLE moves to ST_FETCH_AHI on a start. The fetch states ST_FETCH_AHI, ST_FETCH_ALO, ST_FETCH_LEN and ST_FETCH_CTL each advance on acknowledge, and the last one leads to ST_CHECK. ST_CHECK goes to ST_WB_AHI on an error or a zero length, to ST_SKIP for a zero target, and to ST_COPY otherwise. ST_COPY and ST_SKIP each handle one byte per step and leave for ST_WB_AHI after the last byte. The writeback states ST_WB_AHI, ST_WB_ALO, ST_WB_LEN and ST_WB_CTL advance on acknowledge, and ST_WB_CTL returns to ST_IDLE.

Top module: `cfg_dma_engine`

## Requirements
- R1: A register write with `reg_wr_lo`=0 stores the high pointer half. A write with `reg_wr_lo`=1 forms the pointer from the stored high half and the written low half, and raises `busy` on the next cycle. In each half, write-data bits [7:0] carry the most significant byte. The pointer is used with its two low bits cleared.
- R2: At descriptor address D, the descriptor words are: target address high at D+0, target address low at D+4, length at D+8 and control at D+12. Each word is big-endian: the byte at the lowest address is the most significant. On the memory port, the byte at address A sits in lane A mod 4, at bits 8*(A mod 4)+7 down to 8*(A mod 4).
- R3: If control equals 2, the target is nonzero and the request is in range, `length` item bytes are written to consecutive addresses, starting at the target and at the current item offset. Each byte is written with exactly one byte enable set.
- R4: After a successful copy, the descriptor is written back with target = original target + length, length = 0 and control = 0.
- R5: A zero target address writes no item bytes to memory, but still advances the item offset by the length. It writes back target 0, length 0 and control 0.
- R6: A control value other than 2 writes back control = 1 (bit 0 is the error flag). Target and length are written back unchanged, the item offset does not move and no bytes are written.
- R7: A request with offset + length greater than the item size behaves the same as R6.
- R8: `busy` stays high for exactly length + 10 cycles, with length counted as 0 on an error. While `busy` is low there is no memory request and no item advance.
- R9: Register writes of either half that arrive while `busy` is high are ignored.
- R10: `revision` always reads 2.
- R11: Control 2 with length 0 writes no bytes and writes back the target unchanged, length 0 and control 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Pointer register write strobe |
| reg_wr_lo | input | 1 | 1 selects the low (starting) half, 0 the high half |
| reg_wr_data | input | 32 | Pointer half, most significant byte in bits [7:0] |
| busy | output | 1 | A transfer is pending or running |
| revision | output | 32 | Interface revision, constant 2 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 64 | Byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access completes this cycle |
| item_offset | input | 32 | Current offset in the selected item |
| item_size | input | 32 | Size of the selected item in bytes |
| item_byte | input | 8 | Item byte at the current offset |
| item_adv | output | 1 | Advance the item offset by one |

## Verification
When memory answers with no wait states, `busy` rises on the cycle after the low-half write. It then stays high for one start cycle, four fetch cycles, one check cycle, one cycle per copied or skipped byte and four writeback cycles. The bench drives each stimulus on a falling edge and samples on the next falling edge, after the registers have updated. It counts the cycles in which `busy` is high and compares the count with length + 10. The descriptor, the memory contents and the item offset are checked only after `busy` has fallen, when the last writeback has landed. Writes injected while `busy` is high are judged by the final length of the busy window and by the later behaviour of the engine.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int PTR_W      = 2 * WORD_W;

    localparam logic [WORD_W-1:0] CTL_READ    = 32'd2;
    localparam logic [WORD_W-1:0] CTL_ERR     = 32'd1;
    localparam logic [WORD_W-1:0] IF_REVISION = 32'd2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_AHI,
        ST_FETCH_ALO,
        ST_FETCH_LEN,
        ST_FETCH_CTL,
        ST_CHECK,
        ST_COPY,
        ST_SKIP,
        ST_WB_AHI,
        ST_WB_ALO,
        ST_WB_LEN,
        ST_WB_CTL
    } dma_state_e;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_BYTES; i++) begin
            r[8*i +: 8] = w[8*(WORD_BYTES-1-i) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_dma_ptr_reg.sv
module cfg_dma_ptr_reg
    import cfg_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_lo,
    input  logic [WORD_W-1:0] wr_data,
    input  logic             busy,
    output logic [PTR_W-1:0] desc_ptr,
    output logic             start
);

    logic [WORD_W-1:0] hi_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              start_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            ptr_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (wr_en && !busy) begin
                if (wr_lo) begin
                    ptr_q   <= {hi_q, swap_bytes(wr_data)};
                    start_q <= 1'b1;
                end else begin
                    hi_q <= swap_bytes(wr_data);
                end
            end
        end
    end

    assign desc_ptr = ptr_q;
    assign start    = start_q;

endmodule

// File: rtl/cfg_dma_range_chk.sv
module cfg_dma_range_chk
    import cfg_dma_pkg::*;
#(
    parameter int ITEM_W = 32
) (
    input  logic [WORD_W-1:0] ctl,
    input  logic [WORD_W-1:0] len,
    input  logic [ITEM_W-1:0] offset,
    input  logic [ITEM_W-1:0] size,
    output logic              bad
);

    localparam int SUM_W = ((ITEM_W > WORD_W) ? ITEM_W : WORD_W) + 1;

    logic [SUM_W-1:0] end_pos;
    logic [SUM_W-1:0] limit;

    always_comb begin
        end_pos = SUM_W'(offset) + SUM_W'(len);
        limit   = SUM_W'(size);
        bad     = (ctl != CTL_READ) || (end_pos > limit);
    end

endmodule

// File: rtl/cfg_dma_ctrl.sv
module cfg_dma_ctrl
    import cfg_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PTR_W-1:0]  desc_ptr,
    input  logic              bad,
    output logic [WORD_W-1:0] len_cur,
    output logic [WORD_W-1:0] ctl_cur,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [WORD_BYTES-1:0] mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic [7:0]        item_byte,
    output logic              item_adv,
    output logic              active
);

    localparam int LANE_W = $clog2(WORD_BYTES);
    localparam logic [WORD_BYTES-1:0] ALL_LANES = '1;

    dma_state_e state_q, state_d;

    logic [PTR_W-1:0]  tgt_q;
    logic [WORD_W-1:0] len_q;
    logic [WORD_W-1:0] ctl_q;
    logic [PTR_W-1:0]  desc_base;
    logic [WORD_BYTES-1:0] lane_sel;
    logic [WORD_W-1:0] rd_val;

    assign desc_base = desc_ptr & ~PTR_W'(WORD_BYTES - 1);
    assign rd_val    = swap_bytes(mem_rdata);

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lane_sel[g] = (tgt_q[LANE_W-1:0] == LANE_W'(g));
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start)   state_d = ST_FETCH_AHI;
            ST_FETCH_AHI: if (mem_ack) state_d = ST_FETCH_ALO;
            ST_FETCH_ALO: if (mem_ack) state_d = ST_FETCH_LEN;
            ST_FETCH_LEN: if (mem_ack) state_d = ST_FETCH_CTL;
            ST_FETCH_CTL: if (mem_ack) state_d = ST_CHECK;
            ST_CHECK: begin
                if (bad || len_q == '0)  state_d = ST_WB_AHI;
                else if (tgt_q == '0)    state_d = ST_SKIP;
                else                     state_d = ST_COPY;
            end
            ST_COPY:      if (mem_ack && len_q == WORD_W'(1)) state_d = ST_WB_AHI;
            ST_SKIP:      if (len_q == WORD_W'(1))            state_d = ST_WB_AHI;
            ST_WB_AHI:    if (mem_ack) state_d = ST_WB_ALO;
            ST_WB_ALO:    if (mem_ack) state_d = ST_WB_LEN;
            ST_WB_LEN:    if (mem_ack) state_d = ST_WB_CTL;
            ST_WB_CTL:    if (mem_ack) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // descriptor working copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
            len_q <= '0;
            ctl_q <= '0;
        end else begin
            case (state_q)
                ST_FETCH_AHI: if (mem_ack) tgt_q[PTR_W-1:WORD_W] <= rd_val;
                ST_FETCH_ALO: if (mem_ack) tgt_q[WORD_W-1:0]     <= rd_val;
                ST_FETCH_LEN: if (mem_ack) len_q <= rd_val;
                ST_FETCH_CTL: if (mem_ack) ctl_q <= rd_val;
                ST_CHECK:     ctl_q <= bad ? CTL_ERR : '0;
                ST_COPY: begin
                    if (mem_ack) begin
                        tgt_q <= tgt_q + PTR_W'(1);
                        len_q <= len_q - WORD_W'(1);
                    end
                end
                ST_SKIP:      len_q <= len_q - WORD_W'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        item_adv  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CHECK: ;
            ST_FETCH_AHI: begin
                mem_req = 1'b1; mem_be = ALL_LANES;
                mem_addr = desc_base;
            end
            ST_FETCH_ALO: begin
                mem_req = 1'b1; mem_be = ALL_LANES;
                mem_addr = desc_base + PTR_W'(WORD_BYTES);
            end
            ST_FETCH_LEN: begin
                mem_req = 1'b1; mem_be = ALL_LANES;
                mem_addr = desc_base + PTR_W'(2 * WORD_BYTES);
            end
            ST_FETCH_CTL: begin
                mem_req = 1'b1; mem_be = ALL_LANES;
                mem_addr = desc_base + PTR_W'(3 * WORD_BYTES);
            end
            ST_COPY: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tgt_q;
                mem_be    = lane_sel;
                mem_wdata = {WORD_BYTES{item_byte}};
                item_adv  = mem_ack;
            end
            ST_SKIP: item_adv = 1'b1;
            ST_WB_AHI: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_be = ALL_LANES;
                mem_addr  = desc_base;
                mem_wdata = swap_bytes(tgt_q[PTR_W-1:WORD_W]);
            end
            ST_WB_ALO: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_be = ALL_LANES;
                mem_addr  = desc_base + PTR_W'(WORD_BYTES);
                mem_wdata = swap_bytes(tgt_q[WORD_W-1:0]);
            end
            ST_WB_LEN: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_be = ALL_LANES;
                mem_addr  = desc_base + PTR_W'(2 * WORD_BYTES);
                mem_wdata = swap_bytes(len_q);
            end
            ST_WB_CTL: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_be = ALL_LANES;
                mem_addr  = desc_base + PTR_W'(3 * WORD_BYTES);
                mem_wdata = swap_bytes(ctl_q);
            end
            default: ;
        endcase
    end

    assign len_cur = len_q;
    assign ctl_cur = ctl_q;
    assign active  = (state_q != ST_IDLE);

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
    import cfg_dma_pkg::*;
#(
    parameter int ITEM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_wr_lo,
    input  logic [WORD_W-1:0] reg_wr_data,
    output logic              busy,
    output logic [WORD_W-1:0] revision,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [WORD_BYTES-1:0] mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic [ITEM_W-1:0] item_offset,
    input  logic [ITEM_W-1:0] item_size,
    input  logic [7:0]        item_byte,
    output logic              item_adv
);

    logic [PTR_W-1:0]  desc_ptr;
    logic              start;
    logic              active;
    logic              bad;
    logic [WORD_W-1:0] len_cur;
    logic [WORD_W-1:0] ctl_cur;

    assign busy     = start | active;
    assign revision = IF_REVISION;

    cfg_dma_ptr_reg u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_lo    (reg_wr_lo),
        .wr_data  (reg_wr_data),
        .busy     (busy),
        .desc_ptr (desc_ptr),
        .start    (start)
    );

    cfg_dma_range_chk #(.ITEM_W(ITEM_W)) u_chk (
        .ctl    (ctl_cur),
        .len    (len_cur),
        .offset (item_offset),
        .size   (item_size),
        .bad    (bad)
    );

    cfg_dma_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .desc_ptr  (desc_ptr),
        .bad       (bad),
        .len_cur   (len_cur),
        .ctl_cur   (ctl_cur),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .item_byte (item_byte),
        .item_adv  (item_adv),
        .active    (active)
    );

endmodule

// File: rtl/cfg_dma_engine_chk.sv
module cfg_dma_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic        reg_wr_lo,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic [63:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic        mem_ack,
    input logic        item_adv
);

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_lo && !busy) |=> busy); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R2

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1)); // R3

    AST_SKIP_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> (mem_addr != 64'd0)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !item_adv)); // R8

endmodule

bind cfg_dma_engine cfg_dma_engine_chk u_chk_bind (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_wr_lo (reg_wr_lo),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_ack   (mem_ack),
    .item_adv  (item_adv)
);

// File: tb/tb_cfg_dma_engine.sv
module tb_cfg_dma_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_lo = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        busy;
    logic [31:0] revision;
    logic        mem_req, mem_we, mem_ack, item_adv;
    logic [63:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, mem_rdata;
    logic [31:0] item_offset, item_size = 32'd20;
    logic [7:0]  item_byte;

    logic [7:0]  mem_b [256];
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0, host_data = '0;
    logic        off_we = 1'b0;
    logic [31:0] off_val = '0;
    int          oob_count = 0;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    cfg_dma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_lo(reg_wr_lo),
        .reg_wr_data(reg_wr_data), .busy(busy), .revision(revision),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .item_offset(item_offset), .item_size(item_size), .item_byte(item_byte),
        .item_adv(item_adv)
    );

    function automatic logic [7:0] pat(input logic [31:0] n);
        return 8'(n * 7 + 3) ^ 8'h5A;
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // zero-wait memory and item model
    assign mem_ack   = mem_req;
    assign item_byte = pat(item_offset);
    always_comb begin
        mem_rdata = {mem_b[{mem_addr[7:2], 2'd3}], mem_b[{mem_addr[7:2], 2'd2}],
                     mem_b[{mem_addr[7:2], 2'd1}], mem_b[{mem_addr[7:2], 2'd0}]};
    end

    always_ff @(posedge clk) begin
        if (host_we) mem_b[host_addr] <= host_data;
        if (mem_req && mem_we) begin
            for (int i = 0; i < 4; i++)
                if (mem_be[i]) mem_b[{mem_addr[7:2], 2'(i)}] <= mem_wdata[8*i +: 8];
        end
        if (mem_req && mem_addr[63:8] != '0) oob_count <= oob_count + 1;
        if (off_we)        item_offset <= off_val;
        else if (item_adv) item_offset <= item_offset + 32'd1;
    end

    typedef struct packed {
        logic [31:0] ctl;
        logic [7:0]  tgt;
        logic [7:0]  len;
        logic [7:0]  off;
        logic [7:0]  size;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'd2, 8'h10, 8'd5,  8'd0,  8'd20},  // aligned copy
        '{32'd2, 8'h23, 8'd9,  8'd4,  8'd20},  // unaligned copy
        '{32'd2, 8'h00, 8'd6,  8'd3,  8'd20},  // skip
        '{32'd3, 8'h10, 8'd4,  8'd0,  8'd20},  // bad control
        '{32'd2, 8'h10, 8'd10, 8'd15, 8'd20},  // overrun
        '{32'd2, 8'h30, 8'd0,  8'd2,  8'd20},  // zero length
        '{32'd2, 8'h40, 8'd5,  8'd15, 8'd20},  // ends exactly at item end
        '{32'd0, 8'h10, 8'd3,  8'd0,  8'd20}   // control zero
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic put_word(input logic [7:0] a, input logic [31:0] w);
        for (int i = 0; i < 4; i++) host_wr(a + 8'(i), w[31-8*i -: 8]);
    endtask

    function automatic logic [31:0] get_word(input logic [7:0] a);
        return {mem_b[a], mem_b[a+8'd1], mem_b[a+8'd2], mem_b[a+8'd3]};
    endfunction

    task automatic put_desc(input logic [7:0] base, input logic [31:0] tgt,
                            input logic [31:0] len, input logic [31:0] ctl);
        put_word(base, 32'd0);
        put_word(base + 8'd4, tgt);
        put_word(base + 8'd8, len);
        put_word(base + 8'd12, ctl);
    endtask

    task automatic fill_low();
        for (int a = 0; a < 128; a++) host_wr(8'(a), 8'hEE);
    endtask

    task automatic set_offset(input logic [31:0] v);
        off_we = 1'b1; off_val = v;
        @(negedge clk);
        off_we = 1'b0;
    endtask

    task automatic reg_write(input logic lo, input logic [31:0] value);
        reg_wr_en = 1'b1; reg_wr_lo = lo; reg_wr_data = bswap(value);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // start with a low-half write, optionally inject writes while busy, count busy cycles
    task automatic run_xfer(input logic [31:0] lo_val, input bit inject, output int cyc);
        reg_write(1'b1, lo_val);
        cyc = 0;
        while (busy && cyc < 2000) begin
            cyc++;
            if (inject && cyc == 2) begin
                reg_wr_en = 1'b1; reg_wr_lo = 1'b0; reg_wr_data = bswap(32'h1);
            end else if (inject && cyc == 3) begin
                reg_wr_en = 1'b1; reg_wr_lo = 1'b1; reg_wr_data = bswap(32'h90);
            end else begin
                reg_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        reg_wr_en = 1'b0;
    endtask

    task automatic run_vector(input vec_t v);
        bit    err;
        string tag;
        int    cyc, bad_bytes, eff_len;
        logic [7:0] expb;
        err = (v.ctl != 32'd2) || ({1'b0, v.off} + {1'b0, v.len} > {1'b0, v.size});
        if (err)               tag = (v.ctl != 32'd2) ? "R6" : "R7";
        else if (v.len == 0)   tag = "R11";
        else if (v.tgt == 0)   tag = "R5";
        else                   tag = "R4";
        eff_len = err ? 0 : int'(v.len);
        fill_low();
        put_desc(8'h80, {24'd0, v.tgt}, {24'd0, v.len}, v.ctl);
        item_size = {24'd0, v.size};
        set_offset({24'd0, v.off});
        reg_write(1'b0, 32'd0);
        run_xfer(32'h80, 1'b0, cyc);
        check("R8 busy cycles", 64'(cyc), 64'(eff_len + 10));
        check("R2 writeback addr hi", 64'(get_word(8'h80)), 64'd0);
        check({tag, " writeback addr"}, 64'(get_word(8'h84)),
              64'((err || v.tgt == 0) ? int'(v.tgt) : int'(v.tgt) + int'(v.len)));
        check({tag, " writeback length"}, 64'(get_word(8'h88)), err ? 64'(v.len) : 64'd0);
        check({tag, " writeback control"}, 64'(get_word(8'h8C)), err ? 64'd1 : 64'd0);
        check({tag, " item offset"}, 64'(item_offset), 64'(int'(v.off) + eff_len));
        bad_bytes = 0;
        for (int a = 0; a < 128; a++) begin
            expb = 8'hEE;
            if (!err && v.tgt != 0 && a >= int'(v.tgt) && a < int'(v.tgt) + int'(v.len))
                expb = pat(32'(int'(v.off) + a - int'(v.tgt)));
            if (mem_b[a] !== expb) bad_bytes++;
        end
        check((!err && v.tgt != 0 && v.len != 0) ? "R3 copied bytes" : {tag, " memory untouched"},
              64'(bad_bytes), 64'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cyc;
        for (int a = 0; a < 256; a++) mem_b[a] = 8'h00;
        off_we = 1'b1;
        repeat (3) @(negedge clk);
        off_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R8 reset busy", 64'(busy), 64'd0);
        check("R8 reset mem_req", 64'(mem_req), 64'd0);
        check("R8 reset item_adv", 64'(item_adv), 64'd0);
        check("R10 revision", 64'(revision), 64'd2);

        for (int i = 0; i < NV; i++) run_vector(VECS[i]);

        // R9: writes during a transfer are ignored
        fill_low();
        put_desc(8'h80, 32'h50, 32'd8, 32'd2);
        put_desc(8'h90, 32'h60, 32'd3, 32'd2);
        item_size = 32'd20;
        set_offset(32'd0);
        reg_write(1'b0, 32'd0);
        run_xfer(32'h80, 1'b1, cyc);
        check("R9 busy cycles with injected writes", 64'(cyc), 64'd18);
        repeat (20) @(negedge clk);
        check("R9 no second start", 64'(busy), 64'd0);
        check("R9 second descriptor untouched", 64'(get_word(8'h9C)), 64'd2);
        check("R9 second target untouched", 64'(mem_b[8'h60]), 64'hEE);
        check("R3 first copy last byte", 64'(mem_b[8'h57]), 64'(pat(32'd7)));

        // R1: low-half write alone reuses the stored high half
        run_xfer(32'h90, 1'b0, cyc);
        check("R1 busy cycles low-only start", 64'(cyc), 64'd13);
        check("R1 stored high half kept", 64'(oob_count), 64'd0);
        check("R1 copy from item offset", 64'(mem_b[8'h60]), 64'(pat(32'd8)));
        check("R4 writeback addr", 64'(get_word(8'h94)), 64'h63);
        check("R2 control word big-endian", 64'(get_word(8'h9C)), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule